// File: doc/BRIEF.md
# Video Scanline Slot Timing Generator

This block produces the per-scanline access-slot timing for a tile-based video display processor. An 8-bit slot counter advances once for every slot enable and covers one scanline per pass. The counter does not run through every value. In each horizontal mode it jumps over a fixed range of values, so the number of real slots in a line is smaller than 256. The narrow mode has 171 slots per line and the wide mode has 210.

The block decodes the counter value into a set of flags: the active render window, the right border, and the horizontal blank with its three phases (front porch, sync and back porch). It also flags the wide-mode slots that an external clock stage must stretch. Two strobes are produced, one for the horizontal interrupt and one for the vertical interrupt. The vertical strobe fires only when the first-VBLANK-line input is high.

The mode input is sampled only when the counter wraps to 0x00, so a scanline never mixes two modes.

Top module: `slot_timing_gen`

## Requirements
- R1: While `slot_en` is high the counter moves to its next value on each clock edge; while `slot_en` is low it holds. A synchronous active-low reset sets it to 0x00.
- R2: In narrow mode (`wide_act`=0) the counter goes from 0x93 straight to 0xE9 and from 0xFF to 0x00, which gives 171 slots per line.
- R3: In wide mode (`wide_act`=1) the counter goes from 0xB6 straight to 0xE5 and from 0xFF to 0x00, which gives 210 slots per line.
- R4: `render` is high for counter values 0x00–0x7F in narrow mode and 0x00–0x9F in wide mode. That is 128 and 160 slots.
- R5: `border` is high for 0x80–0x8C in narrow mode and 0xA0–0xAC in wide mode, 13 slots in each mode. `hblank` is high for every value above the border. `render`, `border` and `hblank` are mutually exclusive.
- R6: In narrow mode `hfront` covers 0x8D–0x90 (4 slots), `hsync` covers 0x91–0x93 and 0xE9–0xF2 (13 slots), and `hback` covers 0xF3–0xFF (13 slots). That is 30 blank slots.
- R7: In wide mode `hfront` covers 0xAD–0xB1 (5 slots), `hsync` covers 0xB2–0xB6 and 0xE5–0xEF (16 slots), and `hback` covers 0xF0–0xFF (16 slots). That is 37 blank slots.
- R8: `long_slot` is high only in wide mode, for 0xB2–0xB6 and 0xE5–0xF0. These are the 16 sync slots plus the first back-porch slot, 17 in total. It is never high in narrow mode.
- R9: `hint` is high in a cycle only when `slot_en` is high and the counter holds 0x85 (narrow) or 0xA5 (wide). In narrow mode, 38 slots run from the `hint` slot, counting that slot, to the next 0x00.
- R10: `vint` is high in a cycle only when `slot_en` and `first_vblank` are both high and the counter holds 0x01.
- R11: `wide_act` takes the value of `mode_sel` only on the step from 0xFF to 0x00, or during reset. A change of `mode_sel` in the middle of a line has no effect on that line.
- R12: In the cycle after reset is released, the counter reads 0x00 and both `hint` and `vint` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | 1 | Slot enable, one pulse per slot |
| mode_sel | input | 1 | Requested mode: 0 narrow, 1 wide |
| first_vblank | input | 1 | High on the first vertical-blank line |
| slot_cnt | output | 8 | Current slot counter value |
| wide_act | output | 1 | Mode in force for the current line |
| render | output | 1 | Active render window |
| border | output | 1 | Right border |
| hblank | output | 1 | Horizontal blank |
| hfront | output | 1 | Blank front porch |
| hsync | output | 1 | Horizontal sync |
| hback | output | 1 | Blank back porch |
| long_slot | output | 1 | Slot to be stretched by the clock stage |
| hint | output | 1 | Horizontal interrupt strobe |
| vint | output | 1 | Vertical interrupt strobe |

## Verification
The bench walks complete lines in both modes against an independent model of the jump. A wrong gap value would show up as a wrong line length or as a missed jump from 0x93 or 0xB6. Phase boundaries that straddle the gap are checked slot by slot, so a sync flag that dropped at the jump, or a porch that was one slot too long, appears both as a per-slot mismatch and as a wrong phase total. A `mode_sel` change in the middle of a line must leave that line's jump point unchanged; a design that switched immediately would jump at the other mode's value. Stalling on the interrupt slot checks that a strobe not gated by `slot_en` would repeat. The vertical strobe is checked with `first_vblank` both low and high on the same slot.

// File: rtl/slot_timing_pkg.sv
// Package: shared slot type and the per-mode line map for the slot timing
// generator. Assumes an 8-bit slot counter; every boundary is a counter value.
package slot_timing_pkg;

    localparam int CW = 8;

    typedef logic [CW-1:0] slot_t;

    // Last value of each region plus the gap edges, for one horizontal mode.
    typedef struct packed {
        slot_t render_last;
        slot_t border_last;
        slot_t front_last;
        slot_t gap_lo;
        slot_t gap_hi;
        slot_t sync_last;
        slot_t long_last;
        slot_t hint_at;
    } line_map_t;

    localparam slot_t VINT_AT  = 8'h01;
    localparam slot_t LINE_TOP = 8'hFF;

    localparam line_map_t MAP_NARROW = '{
        render_last: 8'h7F, border_last: 8'h8C, front_last: 8'h90,
        gap_lo: 8'h93, gap_hi: 8'hE9, sync_last: 8'hF2,
        long_last: 8'h00, hint_at: 8'h85};

    localparam line_map_t MAP_WIDE = '{
        render_last: 8'h9F, border_last: 8'hAC, front_last: 8'hB1,
        gap_lo: 8'hB6, gap_hi: 8'hE5, sync_last: 8'hEF,
        long_last: 8'hF0, hint_at: 8'hA5};

    // Select the line map for a mode (0 narrow, 1 wide).
    function automatic line_map_t line_map(input logic wide);
        return wide ? MAP_WIDE : MAP_NARROW;
    endfunction

endpackage

// File: rtl/slot_counter.sv
// Slot counter with gap jump and line-boundary mode latch.
// Assumes slot_en is a single-cycle qualifier; one step per enabled cycle.
// The mode is latched during reset and on the 0xFF -> 0x00 step only.
module slot_counter
    import slot_timing_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  slot_en,
    input  logic  mode_sel,
    output slot_t cnt,
    output logic  wide_act
);

    line_map_t map;
    slot_t     nxt;
    logic      at_gap;
    logic      at_top;

    // Pick the map of the mode in force for this line.
    always_comb map = line_map(wide_act);

    // Work out the following counter value, including the gap jump.
    always_comb begin
        at_gap = (cnt == map.gap_lo);
        at_top = (cnt == LINE_TOP);
        if (at_gap)
            nxt = map.gap_hi;
        else
            nxt = cnt + slot_t'(1);
    end

    // Advance the counter one slot per enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (slot_en)
            cnt <= nxt;
    end

    // Latch the requested mode at reset and at each line wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wide_act <= mode_sel;
        else if (slot_en && at_top)
            wide_act <= mode_sel;
    end

endmodule

// File: rtl/slot_region_decode.sv
// Decodes the slot counter into line regions and blank phases.
// Assumes counter values inside the gap never occur; sync straddles the gap.
// HAS_LONG selects whether the stretched-slot flag is built.
module slot_region_decode
    import slot_timing_pkg::*;
#(
    parameter bit HAS_LONG = 1'b1
) (
    input  slot_t cnt,
    input  logic  wide_act,
    output logic  render,
    output logic  border,
    output logic  hblank,
    output logic  hfront,
    output logic  hsync,
    output logic  hback,
    output logic  long_slot
);

    line_map_t map;
    logic      below_gap_sync;
    logic      above_gap_sync;

    // Map of the current mode.
    always_comb map = line_map(wide_act);

    // Region flags from ordered boundaries.
    always_comb begin
        render = (cnt <= map.render_last);
        border = (cnt > map.render_last) && (cnt <= map.border_last);
        hblank = (cnt > map.border_last);
    end

    // Blank phases; sync has one part on each side of the gap.
    always_comb begin
        below_gap_sync = (cnt > map.front_last) && (cnt <= map.gap_lo);
        above_gap_sync = (cnt >= map.gap_hi) && (cnt <= map.sync_last);
        hfront = (cnt > map.border_last) && (cnt <= map.front_last);
        hsync  = below_gap_sync || above_gap_sync;
        hback  = (cnt > map.sync_last);
    end

    generate
        if (HAS_LONG) begin : g_long
            // Stretched slots: wide-mode sync plus one back-porch slot.
            always_comb long_slot = wide_act &&
                (below_gap_sync || ((cnt >= map.gap_hi) && (cnt <= map.long_last)));
        end else begin : g_no_long
            // No stretching in this build.
            always_comb long_slot = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/slot_strobes.sv
// Horizontal and vertical interrupt strobes, one cycle per matching slot.
// Assumes the strobes are gated by slot_en, so a stalled slot never repeats one.
module slot_strobes
    import slot_timing_pkg::*;
(
    input  slot_t cnt,
    input  logic  wide_act,
    input  logic  slot_en,
    input  logic  first_vblank,
    output logic  hint,
    output logic  vint
);

    slot_t hint_slot;

    // Mode-dependent horizontal interrupt slot.
    always_comb hint_slot = line_map(wide_act).hint_at;

    // Strobes fire on the enabled cycle of their slot.
    always_comb begin
        hint = slot_en && (cnt == hint_slot);
        vint = slot_en && first_vblank && (cnt == VINT_AT);
    end

endmodule

// File: rtl/slot_timing_gen.sv
// Top: scanline slot timing generator. Ties counter, region decode and
// strobe logic together. Assumes one clock domain and a synchronous reset.
module slot_timing_gen
    import slot_timing_pkg::*;
#(
    parameter bit HAS_LONG = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_en,
    input  logic       mode_sel,
    input  logic       first_vblank,
    output logic [7:0] slot_cnt,
    output logic       wide_act,
    output logic       render,
    output logic       border,
    output logic       hblank,
    output logic       hfront,
    output logic       hsync,
    output logic       hback,
    output logic       long_slot,
    output logic       hint,
    output logic       vint
);

    slot_t cnt;

    slot_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_en  (slot_en),
        .mode_sel (mode_sel),
        .cnt      (cnt),
        .wide_act (wide_act)
    );

    slot_region_decode #(.HAS_LONG(HAS_LONG)) u_dec (
        .cnt       (cnt),
        .wide_act  (wide_act),
        .render    (render),
        .border    (border),
        .hblank    (hblank),
        .hfront    (hfront),
        .hsync     (hsync),
        .hback     (hback),
        .long_slot (long_slot)
    );

    slot_strobes u_stb (
        .cnt          (cnt),
        .wide_act     (wide_act),
        .slot_en      (slot_en),
        .first_vblank (first_vblank),
        .hint         (hint),
        .vint         (vint)
    );

    // Drive the counter port.
    always_comb slot_cnt = cnt;

endmodule

// File: rtl/slot_timing_chk.sv
// Checker for slot_timing_gen, attached with bind. Observes ports only.
module slot_timing_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slot_en,
    input logic       first_vblank,
    input logic [7:0] slot_cnt,
    input logic       wide_act,
    input logic       render,
    input logic       border,
    input logic       hblank,
    input logic       hfront,
    input logic       hsync,
    input logic       hback,
    input logic       long_slot,
    input logic       hint,
    input logic       vint
);

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n) !slot_en |=> $stable(slot_cnt)); // R1
    AST_NARROW_GAP: assert property (@(posedge clk) disable iff (!rst_n) (slot_en && !wide_act && slot_cnt == 8'h93) |=> slot_cnt == 8'hE9); // R2
    AST_WIDE_GAP: assert property (@(posedge clk) disable iff (!rst_n) (slot_en && wide_act && slot_cnt == 8'hB6) |=> slot_cnt == 8'hE5); // R3
    AST_REGION_ONE: assert property (@(posedge clk) disable iff (!rst_n) $countones({render, border, hblank}) == 1); // R5
    AST_PHASE_COVER: assert property (@(posedge clk) disable iff (!rst_n) hblank == (hfront || hsync || hback) && $onehot0({hfront, hsync, hback})); // R6
    AST_LONG_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) long_slot |-> wide_act && hblank); // R8
    AST_HINT_GATED: assert property (@(posedge clk) disable iff (!rst_n) hint |-> slot_en && border); // R9
    AST_VINT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) vint |=> slot_cnt == 8'h02); // R10
    AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) !$stable(wide_act) |-> slot_cnt == 8'h00); // R11

endmodule

bind slot_timing_gen slot_timing_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_en      (slot_en),
    .first_vblank (first_vblank),
    .slot_cnt     (slot_cnt),
    .wide_act     (wide_act),
    .render       (render),
    .border       (border),
    .hblank       (hblank),
    .hfront       (hfront),
    .hsync        (hsync),
    .hback        (hback),
    .long_slot    (long_slot),
    .hint         (hint),
    .vint         (vint)
);

// File: tb/sim_slot_timing_gen.sv
// Directed bench: one task per scenario, each checks its own results.
module sim_slot_timing_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_en = 1'b0;
    logic       mode_sel = 1'b0;
    logic       first_vblank = 1'b0;
    logic [7:0] slot_cnt;
    logic       wide_act, render, border, hblank, hfront, hsync, hback;
    logic       long_slot, hint, vint;

    int total = 0;
    int bad = 0;

    slot_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .mode_sel(mode_sel),
        .first_vblank(first_vblank), .slot_cnt(slot_cnt), .wide_act(wide_act),
        .render(render), .border(border), .hblank(hblank), .hfront(hfront),
        .hsync(hsync), .hback(hback), .long_slot(long_slot), .hint(hint), .vint(vint)
    );

    always #5 clk = ~clk;

    // Record one check.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_next(input logic [7:0] c, input bit w);
        if (!w && c == 8'h93) return 8'hE9;
        if (w && c == 8'hB6) return 8'hE5;
        return c + 8'd1;
    endfunction

    function automatic bit in_rng(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi);
        return (c >= lo) && (c <= hi);
    endfunction

    // Synchronous reset with a chosen mode; checks the state afterwards.
    task automatic do_reset(input bit m);
        @(negedge clk);
        rst_n = 1'b0; slot_en = 1'b0; mode_sel = m; first_vblank = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(slot_cnt == 8'h00, "R12 cnt after reset", slot_cnt, 0);
        chk(!hint && !vint, "R12 strobes after reset", {hint, vint}, 0);
        chk(wide_act == m, "R11 mode loaded in reset", wide_act, m);
    endtask

    // Walk one whole line, checking every slot and the phase totals.
    task automatic walk_line(input bit w, input bit fv, input bit msel);
        logic [7:0] c = 8'h00;
        int n_r = 0, n_b = 0, n_f = 0, n_s = 0, n_k = 0, n_l = 0, n_h = 0, n_v = 0;
        int hint_idx = -1;
        int len = w ? 210 : 171;
        string rq = w ? "R3" : "R2";
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            slot_en = 1'b1; first_vblank = fv; mode_sel = msel;
            #1;
            chk(slot_cnt == c, rq, slot_cnt, c);
            chk(wide_act == w, "R11 mode held in line", wide_act, w);
            chk(render == (w ? c <= 8'h9F : c <= 8'h7F), "R4 render", render, c);
            chk(border == (w ? in_rng(c, 8'hA0, 8'hAC) : in_rng(c, 8'h80, 8'h8C)), "R5 border", border, c);
            chk(hblank == (w ? c >= 8'hAD : c >= 8'h8D), "R5 hblank", hblank, c);
            chk(hfront == (w ? in_rng(c, 8'hAD, 8'hB1) : in_rng(c, 8'h8D, 8'h90)), w ? "R7 front" : "R6 front", hfront, c);
            chk(hsync == (w ? (in_rng(c, 8'hB2, 8'hB6) || in_rng(c, 8'hE5, 8'hEF))
                            : (in_rng(c, 8'h91, 8'h93) || in_rng(c, 8'hE9, 8'hF2))), w ? "R7 sync" : "R6 sync", hsync, c);
            chk(hback == (w ? c >= 8'hF0 : c >= 8'hF3), w ? "R7 back" : "R6 back", hback, c);
            chk(long_slot == (w && (in_rng(c, 8'hB2, 8'hB6) || in_rng(c, 8'hE5, 8'hF0))), "R8 long", long_slot, c);
            chk(hint == (c == (w ? 8'hA5 : 8'h85)), "R9 hint", hint, c);
            chk(vint == (fv && c == 8'h01), "R10 vint", vint, c);
            n_r += int'(render); n_b += int'(border); n_f += int'(hfront);
            n_s += int'(hsync); n_k += int'(hback); n_l += int'(long_slot);
            n_v += int'(vint);
            if (hint) begin n_h++; hint_idx = i; end
            c = model_next(c, w);
        end
        @(negedge clk);
        slot_en = 1'b0;
        #1;
        chk(slot_cnt == 8'h00, {rq, " wrap"}, slot_cnt, 0);
        chk(n_r == (w ? 160 : 128), "R4 render total", n_r, w ? 160 : 128);
        chk(n_b == 13, "R5 border total", n_b, 13);
        chk(n_f == (w ? 5 : 4), w ? "R7 front total" : "R6 front total", n_f, w ? 5 : 4);
        chk(n_s == (w ? 16 : 13), w ? "R7 sync total" : "R6 sync total", n_s, w ? 16 : 13);
        chk(n_k == (w ? 16 : 13), w ? "R7 back total" : "R6 back total", n_k, w ? 16 : 13);
        chk(n_l == (w ? 17 : 0), "R8 long total", n_l, w ? 17 : 0);
        chk(n_h == 1, "R9 one hint", n_h, 1);
        chk(n_v == (fv ? 1 : 0), "R10 vint count", n_v, fv ? 1 : 0);
        if (!w) chk(len - hint_idx == 38, "R9 hint to wrap", len - hint_idx, 38);
        chk(wide_act == msel, "R11 mode at wrap", wide_act, msel);
    endtask

    // Stall on the interrupt slot: counter holds and strobe stays low.
    task automatic stall_on_hint();
        do_reset(1'b0);
        for (int i = 0; i < 8'h85; i++) begin
            @(negedge clk); slot_en = 1'b1;
        end
        @(negedge clk); slot_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(slot_cnt == 8'h85, "R1 hold", slot_cnt, 8'h85);
            chk(!hint, "R9 hint needs enable", hint, 0);
            @(negedge clk);
        end
        slot_en = 1'b1;
        #1;
        chk(hint, "R9 hint on enable", hint, 1);
        @(negedge clk); slot_en = 1'b0;
        #1;
        chk(slot_cnt == 8'h86, "R1 step", slot_cnt, 8'h86);
    endtask

    // Vertical strobe depends on the first-VBLANK flag at slot 0x01.
    task automatic vint_gate();
        do_reset(1'b0);
        @(negedge clk); slot_en = 1'b1; first_vblank = 1'b1;
        #1;
        chk(!vint, "R10 no vint at 0x00", vint, 0);
        @(negedge clk); first_vblank = 1'b0;
        #1;
        chk(!vint, "R10 no vint without flag", vint, 0);
        first_vblank = 1'b1;
        #1;
        chk(vint, "R10 vint at 0x01", vint, 1);
        slot_en = 1'b0;
        #1;
        chk(!vint, "R10 vint needs enable", vint, 0);
    endtask

    // Reset in mid-line returns the counter to 0x00.
    task automatic mid_reset();
        do_reset(1'b1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); slot_en = 1'b1;
        end
        @(negedge clk); slot_en = 1'b0;
        #1;
        chk(slot_cnt == 8'd40, "R1 count 40", slot_cnt, 40);
        do_reset(1'b0);
    endtask

    initial begin
        do_reset(1'b0);
        walk_line(1'b0, 1'b0, 1'b0);
        walk_line(1'b0, 1'b1, 1'b1);
        walk_line(1'b1, 1'b1, 1'b1);
        walk_line(1'b1, 1'b0, 1'b0);
        walk_line(1'b0, 1'b0, 1'b0);
        stall_on_hint();
        vint_gate();
        mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule